// File: doc/BRIEF.md
# Full-Scan Test Sequencer

This block steps a full-scan design through its test session. After a start pulse it latches a vector count N and a chain length L. For each vector it runs L shift cycles with scan enable high. It then runs a hold cycle in which the primary outputs are read, a capture cycle with scan enable low, and an observe cycle for the pseudo-primary outputs. After the last vector it runs L-1 further shift cycles to empty the chains. Test mode stays high for the whole session.

Serial data for all balanced chains comes from a vector port. The sequencer presents a vector index and a bit index, and passes the returned word to the chain inputs during vector shifts. Response bits leave the chains while the next vector shifts in. A strobe marks every shift cycle whose chain output is a response bit. A one-cycle completion flag ends the session. At that point a cycle counter reads exactly N(L+3)+L-1 and keeps that value until the next session starts.

Top module: `scan_test_seq`

## Requirements
- R1: After reset the block is idle: test_mode, scan_en, capture_en, po_strobe, ppo_strobe, so_strobe, busy and done are 0, and cycle_count is 0.
- R2: test_mode and busy are 1 in every cycle of a session, from the first shift cycle through the last unload cycle, and 0 outside a session.
- R3: Each vector gets exactly L consecutive shift cycles with scan_en=1. In shift cycle b (0-based) of vector v, bit_index=b, vec_index=v, and scan_in equals vec_data.
- R4: The cycle after a vector's last shift is a hold cycle: scan_en=0 and po_strobe=1.
- R5: The cycle after the hold cycle is a capture cycle: scan_en=0 and capture_en=1.
- R6: The cycle after the capture cycle is an observe cycle: scan_en=0 and ppo_strobe=1. The next vector's shift follows immediately.
- R7: After the observe cycle of the last vector come exactly L-1 unload cycles with scan_en=1 and scan_in all zero. There are none when L=1.
- R8: so_strobe is 1 in the first L-1 shift cycles of every vector except the first, and in every unload cycle. It is 0 in all other cycles, so it is high N(L-1) times per session.
- R9: A session lasts exactly N(L+3)+L-1 busy cycles. cycle_count equals that number when done is 1, and it keeps that value while idle.
- R10: done is 1 for exactly one cycle, the cycle after the last busy cycle. busy is 0 in that cycle.
- R11: A start pulse is ignored while a session is running or done is high. A start pulse with num_vectors=0 or chain_len=0 is also ignored and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a session (taken only when idle) |
| num_vectors | input | VEC_W | Number of test vectors N |
| chain_len | input | LEN_W | Balanced chain length L |
| vec_data | input | CHAINS | Scan-in word returned by the vector port |
| vec_index | output | VEC_W | Vector currently being shifted in |
| bit_index | output | LEN_W | Shift position within the vector |
| scan_in | output | CHAINS | Serial data to the chain inputs |
| test_mode | output | 1 | Test-mode control, high for the session |
| scan_en | output | 1 | Scan enable, high on shift and unload cycles |
| capture_en | output | 1 | Capture-clock enable |
| po_strobe | output | 1 | Sample primary outputs |
| ppo_strobe | output | 1 | Sample pseudo-primary outputs |
| so_strobe | output | 1 | Sample chain outputs as response bits |
| busy | output | 1 | Session running |
| done | output | 1 | One-cycle completion flag |
| cycle_count | output | CNT_W | Elapsed session cycles, frozen after completion |

## Verification
The assertions assume that num_vectors and chain_len change only meaningfully at a start pulse. They also assume that vec_data is a combinational function of the presented indices. The bench meets both assumptions: it drives the length and count fields only together with start, and it models the vector port as a fixed function of vec_index and bit_index. Start pulses that arrive during a session, and zero counts or lengths, are injected on purpose to exercise the ignore rule.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SHIFT  = 3'd1,
      PH_HOLD   = 3'd2,
      PH_CAPT   = 3'd3,
      PH_OBS    = 3'd4,
      PH_UNLOAD = 3'd5,
      PH_DONE   = 3'd6
   } phase_t;

   function automatic int unsigned count_width(input int unsigned vw, input int unsigned lw);
      return vw + lw + 2;
   endfunction

endpackage

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
   import scan_seq_pkg::*;
#(
   parameter int unsigned VEC_W = 16,
   parameter int unsigned LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [VEC_W-1:0] num_vectors,
   input  logic [LEN_W-1:0] chain_len,
   output phase_t           phase,
   output logic [VEC_W-1:0] vec_idx,
   output logic [LEN_W-1:0] bit_idx,
   output logic             so_valid,
   output logic             session_go
);

   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
   localparam logic [LEN_W-1:0] LEN_TWO = LEN_W'(2);

   logic [VEC_W-1:0] n_r;
   logic [LEN_W-1:0] len_r;
   logic             last_bit;
   logic             last_vec;
   logic             last_unload;

   assign session_go  = start && (phase == PH_IDLE) && (num_vectors != '0) && (chain_len != '0);
   assign last_bit    = (bit_idx == len_r - LEN_ONE);
   assign last_vec    = (vec_idx == n_r - VEC_W'(1));
   assign last_unload = (bit_idx == len_r - LEN_TWO);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         n_r     <= '0;
         len_r   <= '0;
         vec_idx <= '0;
         bit_idx <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: begin
               if (session_go) begin
                  n_r     <= num_vectors;
                  len_r   <= chain_len;
                  vec_idx <= '0;
                  bit_idx <= '0;
                  phase   <= PH_SHIFT;
               end
            end
            PH_SHIFT: begin
               if (last_bit) begin
                  bit_idx <= '0;
                  phase   <= PH_HOLD;
               end else begin
                  bit_idx <= bit_idx + LEN_ONE;
               end
            end
            PH_HOLD: phase <= PH_CAPT;
            PH_CAPT: phase <= PH_OBS;
            PH_OBS: begin
               if (!last_vec) begin
                  vec_idx <= vec_idx + VEC_W'(1);
                  phase   <= PH_SHIFT;
               end else if (len_r == LEN_ONE) begin
                  phase   <= PH_DONE;
               end else begin
                  phase   <= PH_UNLOAD;
               end
            end
            PH_UNLOAD: begin
               if (last_unload) begin
                  bit_idx <= '0;
                  phase   <= PH_DONE;
               end else begin
                  bit_idx <= bit_idx + LEN_ONE;
               end
            end
            PH_DONE: phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign so_valid = (phase == PH_UNLOAD) ||
                     ((phase == PH_SHIFT) && (vec_idx != '0) && !last_bit);

   // Shift position never reaches the latched length
   assert_bit_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SHIFT) |-> (bit_idx < len_r));

   // A start pulse during a session leaves the latched geometry untouched
   assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (phase != PH_IDLE)) |=> ($stable(len_r) && $stable(n_r)));

   // Hold, capture and observe follow each other in order
   assert_hold_to_capt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_HOLD) |=> (phase == PH_CAPT));
   assert_capt_to_obs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_CAPT) |=> (phase == PH_OBS));

endmodule

// File: rtl/scan_seq_cycle_ctr.sv
module scan_seq_cycle_ctr #(
   parameter int unsigned CNT_W = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   output logic [CNT_W-1:0] count
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (clear) count <= '0;
      else if (run)   count <= count + CNT_W'(1);
   end

   // Counter advances by one on each busy cycle
   assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !clear) |=> (count == $past(count) + CNT_W'(1)));

   // Counter is frozen outside a session
   assert_count_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clear) |=> $stable(count));

endmodule

// File: rtl/scan_seq_datapath.sv
module scan_seq_datapath #(
   parameter int unsigned CHAINS   = 4,
   parameter bit          FILL_ONE = 1'b0
) (
   input  logic              load_vec,
   input  logic              unload,
   input  logic [CHAINS-1:0] vec_data,
   output logic [CHAINS-1:0] scan_in
);

   for (genvar c = 0; c < CHAINS; c++) begin : g_chain
      if (FILL_ONE) begin : g_fill1
         assign scan_in[c] = load_vec ? vec_data[c] : unload;
      end else begin : g_fill0
         assign scan_in[c] = load_vec & vec_data[c];
      end
   end

endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
   import scan_seq_pkg::*;
#(
   parameter int unsigned CHAINS = 4,
   parameter int unsigned VEC_W  = 16,
   parameter int unsigned LEN_W  = 12,
   localparam int unsigned CNT_W = count_width(VEC_W, LEN_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VEC_W-1:0]  num_vectors,
   input  logic [LEN_W-1:0]  chain_len,
   input  logic [CHAINS-1:0] vec_data,
   output logic [VEC_W-1:0]  vec_index,
   output logic [LEN_W-1:0]  bit_index,
   output logic [CHAINS-1:0] scan_in,
   output logic              test_mode,
   output logic              scan_en,
   output logic              capture_en,
   output logic              po_strobe,
   output logic              ppo_strobe,
   output logic              so_strobe,
   output logic              busy,
   output logic              done,
   output logic [CNT_W-1:0]  cycle_count
);

   initial begin
      assert (CHAINS >= 1) else $error("CHAINS must be at least 1");
      assert (VEC_W >= 1 && VEC_W <= 24) else $error("VEC_W out of range");
      assert (LEN_W >= 2 && LEN_W <= 24) else $error("LEN_W out of range");
   end

   phase_t phase;
   logic   so_valid;
   logic   session_go;

   scan_seq_fsm #(.VEC_W(VEC_W), .LEN_W(LEN_W)) fsm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .num_vectors(num_vectors),
      .chain_len  (chain_len),
      .phase      (phase),
      .vec_idx    (vec_index),
      .bit_idx    (bit_index),
      .so_valid   (so_valid),
      .session_go (session_go)
   );

   assign busy       = (phase != PH_IDLE) && (phase != PH_DONE);
   assign done       = (phase == PH_DONE);
   assign test_mode  = busy;
   assign scan_en    = (phase == PH_SHIFT) || (phase == PH_UNLOAD);
   assign capture_en = (phase == PH_CAPT);
   assign po_strobe  = (phase == PH_HOLD);
   assign ppo_strobe = (phase == PH_OBS);
   assign so_strobe  = so_valid;

   scan_seq_cycle_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(session_go),
      .run  (busy),
      .count(cycle_count)
   );

   scan_seq_datapath #(.CHAINS(CHAINS), .FILL_ONE(1'b0)) dp_i (
      .load_vec(phase == PH_SHIFT),
      .unload  (phase == PH_UNLOAD),
      .vec_data(vec_data),
      .scan_in (scan_in)
   );

   // Scan enable only inside an active test session
   assert_se_in_test_R2: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |-> test_mode);

   // Capture happens with the chains out of shift configuration
   assert_capture_no_se_R5: assert property (@(posedge clk) disable iff (!rst_n)
      capture_en |-> !scan_en);

   // At most one control strobe per cycle
   assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({capture_en, po_strobe, ppo_strobe, done}));

   // Completion is a single-cycle pulse followed by idle
   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // Response sampling only on shift cycles
   assert_so_in_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
      so_strobe |-> scan_en);

endmodule

// File: tb/scan_test_seq_tb_top.sv
module scan_test_seq_tb_top;

   localparam int unsigned CHAINS = 4;
   localparam int unsigned VEC_W  = 16;
   localparam int unsigned LEN_W  = 12;
   localparam int unsigned CNT_W  = VEC_W + LEN_W + 2;

   // Session table: {N, L, cycle at which a stray start is injected (-1 none)}
   localparam int NCASE = 7;
   localparam int CASES [NCASE][3] = '{
      '{1, 1, -1},
      '{1, 4, -1},
      '{3, 5,  2},
      '{2, 1,  4},
      '{4, 3, -1},
      '{2, 8, 11},
      '{5, 2, -1}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [VEC_W-1:0]  num_vectors = '0;
   logic [LEN_W-1:0]  chain_len = '0;
   logic [CHAINS-1:0] vec_data;
   logic [VEC_W-1:0]  vec_index;
   logic [LEN_W-1:0]  bit_index;
   logic [CHAINS-1:0] scan_in;
   logic test_mode, scan_en, capture_en, po_strobe, ppo_strobe, so_strobe, busy, done;
   logic [CNT_W-1:0]  cycle_count;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   function automatic logic [CHAINS-1:0] pattern(input int v, input int b);
      return CHAINS'(v * 7 + b * 3 + 5);
   endfunction

   always_comb vec_data = pattern(int'(vec_index), int'(bit_index));

   scan_test_seq #(.CHAINS(CHAINS), .VEC_W(VEC_W), .LEN_W(LEN_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .num_vectors(num_vectors), .chain_len(chain_len), .vec_data(vec_data),
      .vec_index(vec_index), .bit_index(bit_index), .scan_in(scan_in),
      .test_mode(test_mode), .scan_en(scan_en), .capture_en(capture_en),
      .po_strobe(po_strobe), .ppo_strobe(ppo_strobe), .so_strobe(so_strobe),
      .busy(busy), .done(done), .cycle_count(cycle_count)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   // compare all controls against one expected cycle
   task automatic chk_cycle(input string req, input bit se, input bit cap, input bit po,
                            input bit ppo, input bit so, input bit bsy, input bit dn,
                            input logic [CHAINS-1:0] si);
      chk({req, " scan_en"},    scan_en,    se);
      chk({req, " capture_en"}, capture_en, cap);
      chk({req, " po_strobe"},  po_strobe,  po);
      chk({req, " ppo_strobe"}, ppo_strobe, ppo);
      chk({req, " so_strobe R8"}, so_strobe, so);
      chk({req, " busy R2"},    busy,       bsy);
      chk({req, " test_mode R2"}, test_mode, bsy);
      chk({req, " done R10"},   done,       dn);
      chk({req, " scan_in"},    scan_in,    si);
   endtask

   task automatic run_session(input int n, input int l, input int inj);
      int k = 0;
      int so_seen = 0;
      @(negedge clk);
      num_vectors = VEC_W'(n);
      chain_len   = LEN_W'(l);
      start       = 1'b1;
      for (int v = 0; v < n; v++) begin
         for (int b = 0; b < l; b++) begin
            @(negedge clk); start = 1'b0;
            chk_cycle("R3 shift", 1, 0, 0, 0, (v != 0) && (b != l - 1), 1, 0, pattern(v, b));
            chk("R3 bit_index", bit_index, b);
            chk("R3 vec_index", vec_index, v);
            if (so_strobe) so_seen++;
            if (k == inj) begin start = 1'b1; num_vectors = 1; chain_len = 2; end
            k++;
         end
         @(negedge clk); start = 1'b0;
         chk_cycle("R4 hold", 0, 0, 1, 0, 0, 1, 0, '0);
         if (k == inj) begin start = 1'b1; num_vectors = 1; chain_len = 2; end
         k++;
         @(negedge clk); start = 1'b0;
         chk_cycle("R5 capture", 0, 1, 0, 0, 0, 1, 0, '0);
         k++;
         @(negedge clk); start = 1'b0;
         chk_cycle("R6 observe", 0, 0, 0, 1, 0, 1, 0, '0);
         k++;
      end
      for (int u = 0; u < l - 1; u++) begin
         @(negedge clk); start = 1'b0;
         chk_cycle("R7 unload", 1, 0, 0, 0, 1, 1, 0, '0);
         if (so_strobe) so_seen++;
         if (k == inj) begin start = 1'b1; num_vectors = 3; chain_len = 3; end
         k++;
      end
      @(negedge clk); start = 1'b1;  // R11: start during done is ignored
      chk_cycle("R10 done", 0, 0, 0, 0, 0, 0, 1, '0);
      chk("R9 busy cycles", k, n * (l + 3) + l - 1);
      chk("R9 cycle_count at done", cycle_count, n * (l + 3) + l - 1);
      chk("R8 so_strobe count", so_seen, n * (l - 1));
      @(negedge clk); start = 1'b0;
      chk("R11 start in done ignored", busy, 0);
      chk("R10 done cleared", done, 0);
      repeat (2) @(negedge clk);
      chk("R9 cycle_count frozen", cycle_count, n * (l + 3) + l - 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk_cycle("R1 reset", 0, 0, 0, 0, 0, 0, 0, '0);
      chk("R1 cycle_count", cycle_count, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after release", busy, 0);

      for (int i = 0; i < NCASE; i++) run_session(CASES[i][0], CASES[i][1], CASES[i][2]);

      // R11: zero vector count and zero chain length are refused
      @(negedge clk); num_vectors = 0; chain_len = 5; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk("R11 zero N ignored", busy, 0);
      num_vectors = 3; chain_len = 0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk("R11 zero L ignored", busy, 0);
      @(negedge clk);
      chk("R11 zero start leaves count", cycle_count, 5 * (2 + 3) + 2 - 1);

      // R2: a mid-session reset returns to idle
      @(negedge clk); num_vectors = 2; chain_len = 3; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk("R2 busy after start", test_mode, 1);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset mid-session", test_mode, 0);
      chk("R1 reset count", cycle_count, 0);
      rst_n = 1'b1;
      run_session(3, 2, 7);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule